// File: doc/BRIEF.md
# Windowed Reloading Up-Counter

This block is a 16-bit up-counter that serves as a time base. Its count runs from a start value toward a stop value, both supplied at the ports. When the count equals the stop value, a terminal-count flag goes high. An active-low load input makes the next gated count step load the start value instead of incrementing. If the load input is tied to the inverted terminal count, the counter repeats the same start-to-stop window on its own.

A count step happens only on a clock edge where both count-enable inputs are high. One enable is typically a divided-clock rising-edge tick and the other is a general gate.

A host can overwrite the live count one byte at a time through a write strobe, an 8-bit address and an 8-bit data bus. The upper six address bits must match the block's ID input. The lowest two address bits pick the byte lane.

Top module: `win_cnt`

## Requirements
- R1: On an edge where both enables are high, load_ni is high and no host write hits, the count increases by one.
- R2: On an edge where either enable is low and no host write hits, the count holds its value.
- R3: tc_o is high exactly while count_o equals stop_i.
- R4: On an edge where both enables are high and load_ni is low, the count takes the value start_i.
- R5: load_ni low has no effect on an edge where either enable is low.
- R6: A host write whose address matches the block writes the data byte into one byte of the count. Address select 0 writes bits 7:0 and select 1 writes bits 15:8. The other byte is unchanged. A host write has priority over counting and reloading on the same edge.
- R7: A host write is ignored if address bits 7:2 differ from id_i, or if address bits 1:0 select 2 or 3.
- R8: Past the stop value the count keeps incrementing. After 16'hFFFF it rolls over to 16'h0000.
- R9: While reset is asserted, count_o shows start_i and tc_o is low. On the first edge after reset is released, the counter register takes start_i and all other inputs are ignored.
- R10: With load_ni driven by the inverse of tc_o, gated steps produce the repeating sequence start, start+1, ..., stop, start, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_i | input | 1 | Count enable, first |
| ce2_i | input | 1 | Count enable, second |
| load_ni | input | 1 | Reload start on next gated step, active low |
| start_i | input | 16 | Window start value |
| stop_i | input | 16 | Window stop value |
| id_i | input | 6 | Block select ID for host writes |
| addr_i | input | 8 | Host address: bits 7:2 ID, bits 1:0 byte select |
| data_i | input | 8 | Host write data |
| wr_i | input | 1 | Host write strobe |
| count_o | output | 16 | Current count |
| tc_o | output | 1 | Terminal count, high when count equals stop |

## Verification
The bench builds the block with its default 16-bit count, 8-bit address and 6-bit ID. The ID is tied to 6'h11, and the window is set small, from 5 to 9, so the reload and automatic wraparound occur within a few steps. Because the count is two bytes wide, both host byte lanes and the unused selects can be exercised. Writing 16'hFFFF brings the full-scale rollover within one step.

// File: rtl/win_cnt_pkg.sv
package win_cnt_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned lanes(input int unsigned w);
    return (w + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/win_cnt_hostif.sv
module win_cnt_hostif #(
  parameter int unsigned AW   = 8,
  parameter int unsigned IDW  = 6,
  parameter int unsigned NB   = 2,
  localparam int unsigned SELW = AW - IDW
) (
  input  logic [IDW-1:0] id_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_i,
  output logic [NB-1:0]  byte_we_o
);
  logic hit;
  assign hit = wr_i && (addr_i[AW-1:SELW] == id_i);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign byte_we_o[b] = hit && (addr_i[SELW-1:0] == SELW'(b));
  end
endmodule

// File: rtl/win_cnt_core.sv
module win_cnt_core #(
  parameter int unsigned W  = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          load_ni,
  input  logic [W-1:0]  start_i,
  input  logic [NB-1:0] byte_we_i,
  input  logic [DW-1:0] data_i,
  output logic [W-1:0]  count_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         armed_q;

  always_comb begin
    cnt_d = cnt_q;
    if (|byte_we_i) begin
      for (int i = 0; i < W; i++)
        if (byte_we_i[i/DW]) cnt_d[i] = data_i[i%DW];
    end else if (step_i) begin
      cnt_d = load_ni ? cnt_q + W'(1) : start_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      cnt_q   <= start_i;
      armed_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // before first edge the register is not yet loaded
  assign count_o = armed_q ? cnt_q : start_i;

  AST_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && step_i && load_ni && !(|byte_we_i) |=> cnt_q == $past(cnt_q) + W'(1)); // R1
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !step_i && !(|byte_we_i) |=> cnt_q == $past(cnt_q)); // R2
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && step_i && !load_ni && !(|byte_we_i) |=> cnt_q == $past(start_i)); // R4
  AST_LOAD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !step_i && !load_ni && !(|byte_we_i) |=> $stable(cnt_q)); // R5
  AST_BYTE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && byte_we_i[0] |=> cnt_q[DW-1:0] == $past(data_i)); // R6
  AST_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> cnt_q == $past(start_i)); // R9
endmodule

// File: rtl/win_cnt_cmp.sv
module win_cnt_cmp #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] stop_i,
  output logic         tc_o
);
  assign tc_o = (cnt_i == stop_i);
endmodule

// File: rtl/win_cnt.sv
module win_cnt #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned IDW   = 6,
  localparam int unsigned DW   = win_cnt_pkg::BYTE_W,
  localparam int unsigned NB   = win_cnt_pkg::lanes(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce1_i,
  input  logic             ce2_i,
  input  logic             load_ni,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] stop_i,
  input  logic [IDW-1:0]   id_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic             wr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);
  logic [NB-1:0] byte_we;
  logic          step;

  assign step = ce1_i && ce2_i;

  win_cnt_hostif #(.AW(AW), .IDW(IDW), .NB(NB)) u_hostif (
    .id_i(id_i), .addr_i(addr_i), .wr_i(wr_i), .byte_we_o(byte_we)
  );

  win_cnt_core #(.W(CNT_W), .DW(DW), .NB(NB)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .load_ni(load_ni),
    .start_i(start_i), .byte_we_i(byte_we), .data_i(data_i), .count_o(count_o)
  );

  win_cnt_cmp #(.W(CNT_W)) u_cmp (
    .cnt_i(count_o), .stop_i(stop_i), .tc_o(tc_o)
  );

  AST_NO_WR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (addr_i[AW-1:AW-IDW] != id_i) |-> byte_we == '0); // R7
endmodule

// File: tb/sim_win_cnt.sv
module sim_win_cnt;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce1 = 0, ce2 = 0, ld_v = 1, wr = 0, auto_wrap = 0;
  logic [7:0]  addr = 0, data = 0;
  logic [15:0] start = 16'd5, stop = 16'd9;
  logic [15:0] count;
  logic        tc, load_n;
  int          nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  assign load_n = auto_wrap ? ~tc : ld_v;

  win_cnt u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ce1_i(ce1), .ce2_i(ce2), .load_ni(load_n),
    .start_i(start), .stop_i(stop), .id_i(6'h11), .addr_i(addr), .data_i(data),
    .wr_i(wr), .count_o(count), .tc_o(tc)
  );

  // {ce1, ce2, ld_n, wr, addr, data, exp_count, 3'b0, exp_tc}
  localparam int NV = 18;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,16'h0006,3'b0,1'b0}, // R1
    {1'b1,1'b0,1'b1,1'b0,8'h00,8'h00,16'h0006,3'b0,1'b0}, // R2
    {1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,16'h0006,3'b0,1'b0}, // R2
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,16'h0007,3'b0,1'b0}, // R1
    {1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,16'h0005,3'b0,1'b0}, // R4
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,16'h0006,3'b0,1'b0}, // R1
    {1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,16'h0006,3'b0,1'b0}, // R5
    {1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,16'h0006,3'b0,1'b0}, // R5
    {1'b1,1'b1,1'b0,1'b1,8'h44,8'h20,16'h0020,3'b0,1'b0}, // R6 lo, beats reload
    {1'b1,1'b1,1'b1,1'b1,8'h45,8'hA5,16'hA520,3'b0,1'b0}, // R6 hi, beats inc
    {1'b0,1'b0,1'b1,1'b1,8'h84,8'hFF,16'hA520,3'b0,1'b0}, // R7 wrong id
    {1'b0,1'b0,1'b1,1'b1,8'h46,8'hFF,16'hA520,3'b0,1'b0}, // R7 sel 2
    {1'b0,1'b0,1'b1,1'b1,8'h47,8'hFF,16'hA520,3'b0,1'b0}, // R7 sel 3
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,16'hA521,3'b0,1'b0}, // R1
    {1'b0,1'b0,1'b1,1'b1,8'h44,8'h08,16'hA508,3'b0,1'b0}, // R6
    {1'b0,1'b0,1'b1,1'b1,8'h45,8'h00,16'h0008,3'b0,1'b0}, // R6
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,16'h0009,3'b0,1'b1}, // R3
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,16'h000A,3'b0,1'b0}  // R8 past stop
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic c1, input logic c2, input logic l, input logic w,
                      input logic [7:0] a, input logic [7:0] d);
    ce1 = c1; ce2 = c2; ld_v = l; wr = w; addr = a; data = d;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] m;
    #1;
    check("R9 reset count", count, 16'd5);
    check("R9 reset tc", {15'd0, tc}, 16'd0);
    @(negedge clk); rst_ni = 1'b1;
    step(1, 1, 1, 1, 8'h44, 8'h77); // arming edge ignores inputs
    check("R9 arm", count, 16'd5);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][39], VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:28], VEC[i][27:20]);
      check($sformatf("vec %0d count R1-group", i), count, VEC[i][19:4]);
      check($sformatf("vec %0d tc R3", i), {15'd0, tc}, {15'd0, VEC[i][0]});
    end

    // R10 automatic window repeat
    step(0, 0, 1, 1, 8'h44, 8'h05);
    step(0, 0, 1, 1, 8'h45, 8'h00);
    check("R6 set start", count, 16'd5);
    auto_wrap = 1'b1;
    m = 16'd5;
    for (int i = 0; i < 14; i++) begin
      logic g;
      g = (i % 3) != 2;
      step(1, g, 1, 0, 8'h00, 8'h00);
      if (g) m = (m == 16'd9) ? 16'd5 : m + 16'd1;
      check("R10 wrap count", count, m);
      check("R10 wrap tc R3", {15'd0, tc}, {15'd0, (m == 16'd9)});
    end
    auto_wrap = 1'b0;

    // R8 full-scale rollover
    step(0, 0, 1, 1, 8'h44, 8'hFF);
    step(0, 0, 1, 1, 8'h45, 8'hFF);
    check("R8 preset", count, 16'hFFFF);
    step(1, 1, 1, 0, 8'h00, 8'h00);
    check("R8 rollover", count, 16'h0000);

    // R9 reset mid-run
    step(1, 1, 1, 0, 8'h00, 8'h00);
    rst_ni = 1'b0; #3;
    check("R9 async count", count, 16'd5);
    check("R9 async tc", {15'd0, tc}, 16'd0);
    @(negedge clk); rst_ni = 1'b1;
    step(0, 0, 1, 0, 8'h00, 8'h00);
    check("R9 after release", count, 16'd5);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule